// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This block forms the product of two 16-bit operands and folds it into a 35-bit running accumulator. Each operand sits in its own input register, and each register has its own load strobe. Four control bits travel with the operands: operand format, rounding, accumulate and subtract. They are latched whenever either operand register loads. The held product can take one of three paths into the accumulator. It can overwrite the accumulator, it can be added to it, or the accumulator can be taken away from it. A separate preload path writes an arbitrary 35-bit value straight into the accumulator.

The block runs on one system clock. Three enable strobes take the place of independent register clocks: `x_en` loads the X operand, `y_en` loads the Y operand, and `p_en` updates the accumulator. The product path between the input registers and the accumulator is purely combinational. As a result, an accumulator update uses whatever operands and controls were captured on earlier edges. The accumulator value is always visible on `acc_out`.

Top module: `mac_unit`

## Requirements
- R1: `x_in` is captured only on an edge where `x_en` is high, and `y_in` only on an edge where `y_en` is high. An operand whose strobe is low keeps its previous value.
- R2: The control bits (`ctl_signed`, `ctl_round`, `ctl_acc`, `ctl_sub`) are captured on any edge where `x_en` or `y_en` is high. When both strobes are high, the bits are captured once from the current inputs. Otherwise the control bits hold.
- R3: With the captured format bit high, both operands are two's complement and the 32-bit product is sign-extended to 35 bits.
- R4: With the captured format bit low, both operands are unsigned and the product is zero-filled to 35 bits.
- R5: With the captured round bit high, 2^15 is added to the extended product before accumulation. With it low, the product is used unchanged.
- R6: On `p_en` with `preload` low and the captured accumulate bit low, the accumulator is overwritten with the extended product.
- R7: On `p_en` with `preload` low, accumulate high and subtract low, the accumulator becomes the product plus its previous value.
- R8: On `p_en` with `preload` low, accumulate high and subtract high, the accumulator becomes the product minus its previous value.
- R9: On `p_en` with `preload` high, the accumulator takes `preload_data`, whatever the accumulate and subtract bits are.
- R10: The accumulator changes only on an edge where `p_en` is high, apart from reset.
- R11: Accumulator arithmetic wraps modulo 2^35 and carries no overflow indication.
- R12: A low `rst_n` at a clock edge clears both operand registers, the control bits and the accumulator to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_en | input | 1 | Load strobe for the X operand and control bits |
| y_en | input | 1 | Load strobe for the Y operand and control bits |
| p_en | input | 1 | Accumulator update strobe |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| ctl_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| ctl_round | input | 1 | 1 = add 2^15 to the product |
| ctl_acc | input | 1 | 1 = combine with the accumulator, 0 = overwrite it |
| ctl_sub | input | 1 | With accumulate: 1 = product minus accumulator, 0 = sum |
| preload | input | 1 | 1 = load `preload_data` on `p_en` |
| preload_data | input | 35 | External accumulator preload value |
| acc_out | output | 35 | Accumulator contents |

## Verification
An operand strobe takes effect at its edge, and the product is combinational from the registered operands. The earliest edge at which a new operand can reach the accumulator is therefore the `p_en` edge that follows the operand load. Because of this, the bench always loads operands in one cycle and pulses `p_en` in the next. It drives both at falling edges and reads `acc_out` at the falling edge right after the `p_en` edge, which is exactly one register after the stimulus. The hold checks work differently: they leave `p_en` low for several cycles while operands and controls change, and then compare `acc_out` at a falling edge. A reset check is sampled one falling edge after `rst_n` is lowered.

// File: rtl/mac_pkg.sv
// Shared widths and the control-word type for the multiply-accumulate unit.
package mac_pkg;

    localparam int unsigned OP_W  = 16;
    localparam int unsigned ACC_W = 35;
    localparam int unsigned RND_POS = 15;

    // Control bits latched together with either operand.
    typedef struct packed {
        logic is_signed;
        logic do_round;
        logic do_acc;
        logic do_sub;
    } mac_ctl_t;

endpackage

// File: rtl/mac_operand_regs.sv
// Operand and control input registers.
// X loads on x_en and Y loads on y_en. The control word loads on either strobe.
// Assumes a synchronous, active-low reset that clears everything to zero.
module mac_operand_regs
    import mac_pkg::*;
#(
    parameter int unsigned XW = 16,
    parameter int unsigned YW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_en,
    input  logic          y_en,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    input  mac_ctl_t      ctl_in,
    output logic [XW-1:0] x_q,
    output logic [YW-1:0] y_q,
    output mac_ctl_t      ctl_q
);

    // X operand register
    always_ff @(posedge clk) begin
        if (!rst_n)    x_q <= '0;
        else if (x_en) x_q <= x_in;
    end

    // Y operand register
    always_ff @(posedge clk) begin
        if (!rst_n)    y_q <= '0;
        else if (y_en) y_q <= y_in;
    end

    // Control word, captured once when either strobe fires
    always_ff @(posedge clk) begin
        if (!rst_n)            ctl_q <= '0;
        else if (x_en || y_en) ctl_q <= ctl_in;
    end

endmodule

// File: rtl/mac_product.sv
// Combinational product path.
// Multiplies in signed or unsigned format, extends the result to the
// accumulator width, and optionally adds one at the rounding position.
// Assumes AW >= XW + YW + 2 and RP < AW.
module mac_product #(
    parameter int unsigned XW = 16,
    parameter int unsigned YW = 16,
    parameter int unsigned AW = 35,
    parameter int unsigned RP = 15
) (
    input  logic [XW-1:0] x_op,
    input  logic [YW-1:0] y_op,
    input  logic          is_signed,
    input  logic          do_round,
    output logic [AW-1:0] ext_prod
);

    localparam int unsigned MW = XW + YW + 2;

    logic signed [XW:0]   x_wide;
    logic signed [YW:0]   y_wide;
    logic signed [MW-1:0] raw_prod;
    logic [AW-1:0]        ext_raw;
    logic [AW-1:0]        rnd_term;

    // Widen each operand by one bit: a sign copy in signed format, a zero in unsigned
    always_comb begin
        x_wide = {is_signed & x_op[XW-1], x_op};
        y_wide = {is_signed & y_op[YW-1], y_op};
    end

    // A single signed multiplier covers both formats
    assign raw_prod = x_wide * y_wide;

    // Extend to the accumulator width; the widening above already made the sign bit right
    generate
        if (AW > MW) begin : g_ext
            assign ext_raw = {{(AW-MW){raw_prod[MW-1]}}, raw_prod};
        end else begin : g_fit
            assign ext_raw = raw_prod[AW-1:0];
        end
    endgenerate

    // Rounding constant at the rounding position
    always_comb begin
        rnd_term = '0;
        rnd_term[RP] = do_round;
    end

    assign ext_prod = ext_raw + rnd_term;

endmodule

// File: rtl/mac_accum.sv
// Accumulator register.
// On p_en it takes the preload value, overwrites itself with the product,
// adds the product, or becomes product minus itself. Wraps modulo 2^AW.
module mac_accum #(
    parameter int unsigned AW = 35
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_en,
    input  logic          preload,
    input  logic [AW-1:0] preload_data,
    input  logic          do_acc,
    input  logic          do_sub,
    input  logic [AW-1:0] ext_prod,
    output logic [AW-1:0] acc_q
);

    logic [AW-1:0] acc_next;

    // Choose the next accumulator value; preload has the highest priority
    always_comb begin
        if (preload)     acc_next = preload_data;
        else if (!do_acc) acc_next = ext_prod;
        else if (do_sub)  acc_next = ext_prod - acc_q;
        else              acc_next = ext_prod + acc_q;
    end

    // Update only on the product strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (p_en) acc_q <= acc_next;
    end

endmodule

// File: rtl/mac_unit.sv
// Top level of the multiply-accumulate unit.
// Connects the input registers, the product path and the accumulator.
// Single clock, with three strobes standing in for separate register clocks.
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned XW = OP_W,
    parameter int unsigned YW = OP_W,
    parameter int unsigned AW = ACC_W,
    parameter int unsigned RP = RND_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_en,
    input  logic          y_en,
    input  logic          p_en,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    input  logic          ctl_signed,
    input  logic          ctl_round,
    input  logic          ctl_acc,
    input  logic          ctl_sub,
    input  logic          preload,
    input  logic [AW-1:0] preload_data,
    output logic [AW-1:0] acc_out
);

    mac_ctl_t      ctl_in;
    mac_ctl_t      ctl_q;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [AW-1:0] ext_prod;

    // Gather the control inputs into one word
    always_comb begin
        ctl_in.is_signed = ctl_signed;
        ctl_in.do_round  = ctl_round;
        ctl_in.do_acc    = ctl_acc;
        ctl_in.do_sub    = ctl_sub;
    end

    mac_operand_regs #(.XW(XW), .YW(YW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_en   (x_en),
        .y_en   (y_en),
        .x_in   (x_in),
        .y_in   (y_in),
        .ctl_in (ctl_in),
        .x_q    (x_q),
        .y_q    (y_q),
        .ctl_q  (ctl_q)
    );

    mac_product #(.XW(XW), .YW(YW), .AW(AW), .RP(RP)) u_prod (
        .x_op      (x_q),
        .y_op      (y_q),
        .is_signed (ctl_q.is_signed),
        .do_round  (ctl_q.do_round),
        .ext_prod  (ext_prod)
    );

    mac_accum #(.AW(AW)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .p_en         (p_en),
        .preload      (preload),
        .preload_data (preload_data),
        .do_acc       (ctl_q.do_acc),
        .do_sub       (ctl_q.do_sub),
        .ext_prod     (ext_prod),
        .acc_q        (acc_out)
    );

endmodule

// File: rtl/mac_unit_chk.sv
// Assertion checker for mac_unit, attached to it with bind.
// Relates the strobes, the registered state, the product path and the accumulator.
module mac_unit_chk
    import mac_pkg::*;
#(
    parameter int unsigned XW = 16,
    parameter int unsigned YW = 16,
    parameter int unsigned AW = 35
) (
    input logic          clk,
    input logic          rst_n,
    input logic          x_en,
    input logic          y_en,
    input logic          p_en,
    input logic          preload,
    input logic [AW-1:0] preload_data,
    input logic [XW-1:0] x_q,
    input logic [YW-1:0] y_q,
    input mac_ctl_t      ctl_q,
    input logic [AW-1:0] ext_prod,
    input logic [AW-1:0] acc_out
);

    localparam int unsigned PW = XW + YW;

    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !x_en |=> $stable(x_q)); // R1
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !y_en |=> $stable(y_q)); // R1
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_en || y_en) |=> $stable(ctl_q)); // R2
    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.is_signed |-> (ext_prod[AW-1:PW] == {(AW-PW){ext_prod[PW-1]}})); // R3
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.is_signed |-> (ext_prod[AW-1:PW] == '0)); // R4
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en && !preload && !ctl_q.do_acc) |=> (acc_out == $past(ext_prod))); // R6
    AST_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en && !preload && ctl_q.do_acc && !ctl_q.do_sub)
        |=> (acc_out == AW'($past(ext_prod) + $past(acc_out)))); // R7
    AST_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en && !preload && ctl_q.do_acc && ctl_q.do_sub)
        |=> (acc_out == AW'($past(ext_prod) - $past(acc_out)))); // R8
    AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_en && preload) |=> (acc_out == $past(preload_data))); // R9
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !p_en |=> $stable(acc_out)); // R10
    AST_RESET_CLR: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && x_q == '0 && y_q == '0)); // R12

endmodule

bind mac_unit mac_unit_chk #(.XW(XW), .YW(YW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .x_en         (x_en),
    .y_en         (y_en),
    .p_en         (p_en),
    .preload      (preload),
    .preload_data (preload_data),
    .x_q          (x_q),
    .y_q          (y_q),
    .ctl_q        (ctl_q),
    .ext_prod     (ext_prod),
    .acc_out      (acc_out)
);

// File: tb/tb_mac_unit.sv
// Self-checking bench for mac_unit: a vector table, then directed tests.
module tb_mac_unit;

    localparam int unsigned AW = 35;
    localparam int unsigned NV = 11;
    // Vector layout: {signed, round, acc, sub, x[15:0], y[15:0], expected acc[34:0]}
    localparam int unsigned VW = 4 + 16 + 16 + AW;

    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b0000, 16'h0003, 16'h0005, 35'h0_0000_000F},  // unsigned load         R4 R6
        {4'b0010, 16'hFFFF, 16'hFFFF, 35'h0_FFFE_0010},  // unsigned add         R7
        {4'b1000, 16'hFFFE, 16'h0003, 35'h7_FFFF_FFFA},  // signed load -6       R3
        {4'b1010, 16'hFFFF, 16'hFFFF, 35'h7_FFFF_FFFB},  // signed add 1         R7
        {4'b1011, 16'h0002, 16'h0005, 35'h0_0000_000F},  // 10 - (-5)            R8
        {4'b0100, 16'h0001, 16'h0001, 35'h0_0000_8001},  // rounded load         R5
        {4'b1110, 16'h8000, 16'h8000, 35'h0_4001_0001},  // signed round add     R5
        {4'b0011, 16'h0000, 16'h0000, 35'h7_BFFE_FFFF},  // 0 - acc wraps        R8 R11
        {4'b0000, 16'h8000, 16'hFFFF, 35'h0_7FFF_8000},  // unsigned zero-filled R4
        {4'b1000, 16'h8000, 16'hFFFF, 35'h0_0000_8000},  // same bits, signed    R3
        {4'b1011, 16'h7FFF, 16'h7FFF, 35'h0_3FFE_8001}   // signed subtract      R8
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          x_en, y_en, p_en;
    logic [15:0]   x_in, y_in;
    logic          ctl_signed, ctl_round, ctl_acc, ctl_sub;
    logic          preload;
    logic [AW-1:0] preload_data;
    logic [AW-1:0] acc_out;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mac_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .x_en         (x_en),
        .y_en         (y_en),
        .p_en         (p_en),
        .x_in         (x_in),
        .y_in         (y_in),
        .ctl_signed   (ctl_signed),
        .ctl_round    (ctl_round),
        .ctl_acc      (ctl_acc),
        .ctl_sub      (ctl_sub),
        .preload      (preload),
        .preload_data (preload_data),
        .acc_out      (acc_out)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: acc_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic [3:0] c);
        {ctl_signed, ctl_round, ctl_acc, ctl_sub} = c;
    endtask

    // Load operands and controls with the chosen strobes for one cycle.
    task automatic load_ops(input logic [15:0] xv, input logic [15:0] yv,
                            input logic [3:0] c, input logic xe, input logic ye);
        x_in = xv; y_in = yv; set_ctl(c);
        x_en = xe; y_en = ye;
        step();
        x_en = 1'b0; y_en = 1'b0;
    endtask

    // Pulse p_en for one cycle; acc_out is valid at the returning falling edge.
    task automatic pulse_p(input logic pl, input logic [AW-1:0] pd);
        preload = pl; preload_data = pd; p_en = 1'b1;
        step();
        p_en = 1'b0; preload = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; x_en = 0; y_en = 0; p_en = 0;
        x_in = 16'h1234; y_in = 16'h5678; set_ctl(4'b1111);
        preload = 0; preload_data = '0;
        step(); step();
        check("R12 reset", acc_out, '0);
        rst_n = 1'b1;
        step();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            load_ops(VEC[i][VW-5 -: 16], VEC[i][AW +: 16], VEC[i][VW-1 -: 4], 1'b1, 1'b1);
            pulse_p(1'b0, '0);
            check($sformatf("R3-R8 vector %0d", i), acc_out, VEC[i][AW-1:0]);
        end

        // R9: preload ignores accumulate and subtract
        load_ops(16'h0003, 16'h0003, 4'b0011, 1'b1, 1'b1);
        pulse_p(1'b1, 35'h5_A5A5_1234);
        check("R9 preload with sub set", acc_out, 35'h5_A5A5_1234);
        set_ctl(4'b0010);
        pulse_p(1'b1, 35'h0_0000_0042);
        check("R9 preload with add set", acc_out, 35'h0_0000_0042);

        // R10: no p_en means no change, even as operands and strobes move
        load_ops(16'h00FF, 16'h00FF, 4'b0000, 1'b1, 1'b1);
        load_ops(16'h1111, 16'h2222, 4'b1011, 1'b1, 1'b0);
        preload = 1'b1; preload_data = 35'h7_0000_0000;
        step(); step();
        preload = 1'b0;
        check("R10 hold without p_en", acc_out, 35'h0_0000_0042);

        // R1: each operand loads only on its own strobe
        load_ops(16'h0003, 16'h0004, 4'b0000, 1'b1, 1'b1);
        load_ops(16'h0005, 16'h0009, 4'b0000, 1'b1, 1'b0);
        pulse_p(1'b0, '0);
        check("R1 x_en alone keeps Y", acc_out, 35'd20);
        load_ops(16'h0064, 16'h0007, 4'b0000, 1'b0, 1'b1);
        pulse_p(1'b0, '0);
        check("R1 y_en alone keeps X", acc_out, 35'd35);

        // R2: y_en alone captures controls; changed inputs without a strobe do not
        load_ops(16'h0000, 16'h0001, 4'b0010, 1'b0, 1'b1);
        pulse_p(1'b0, '0);
        check("R2 captured by y_en", acc_out, 35'd40);
        set_ctl(4'b0011);
        step();
        pulse_p(1'b0, '0);
        check("R2 held without strobe", acc_out, 35'd45);

        // R11: wrap from the top of the range
        load_ops(16'h0001, 16'h0001, 4'b0010, 1'b1, 1'b1);
        pulse_p(1'b1, 35'h7_FFFF_FFFF);
        pulse_p(1'b0, '0);
        check("R11 wrap to zero", acc_out, '0);

        // R12: reset in the middle of a run
        pulse_p(1'b1, 35'h1_2345_6789);
        rst_n = 1'b0;
        step();
        check("R12 mid-run reset", acc_out, '0);
        rst_n = 1'b1;
        step();
        pulse_p(1'b0, '0);
        check("R12 operands cleared", acc_out, '0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: acc_out=%h expected=completion", acc_out);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule